// File: doc/BRIEF.md
# Rounding Saturating Fixed-Point Multiplier

This block takes two signed two's complement operands that share a fixed number of fraction bits, set by the parameter `FRAC`. It returns their product in that same format. The stored integer of each value equals the real value times 2^FRAC. The full double-width product is formed first. A half-LSB bias of 2^(FRAC-1) is then added, so that exact midpoints round toward positive infinity. The biased product is brought back to the operand scale by an arithmetic right shift of `FRAC` bits. Finally the value is clamped to the signed range of the result word, and a flag marks every result that was clamped.

The input side is a valid/ready pair, and `in_ready` is held high, so an operand pair is taken on every cycle that `in_valid` is high. A two-state controller tracks whether the output register holds a fresh result. In state `ST_EMPTY` no result is pending and `out_valid` is low. In state `ST_FULL` a result from the previous cycle is on the outputs and `out_valid` is high. The transitions are as follows:
- `ST_EMPTY` goes to `ST_FULL` on an accepted input (`take`).
- `ST_FULL` stays in `ST_FULL` on an accepted input (`take_again`).
- `ST_FULL` returns to `ST_EMPTY` when no input arrives (`drain`).
- `ST_EMPTY` stays in `ST_EMPTY` when no input arrives (`idle`).

`FRAC` must lie between 1 and 15. Any other value stops elaboration.

Top module: `fxp_mul_rs`

## Requirements
- R1: A synchronous active-high `rst` sets `out_valid`, `out_sat` and `out_data` to 0 at the next clock edge, even when `in_valid` is high in that cycle.
- R2: `in_ready` is 1 in every cycle outside reset.
- R3: `out_valid` is 1 in exactly the cycles that follow a cycle with `in_valid` high. In every other cycle it is 0.
- R4: The result is the value (a*b + 2^(FRAC-1)) shifted arithmetically right by FRAC, computed without overflow. A midpoint therefore rounds upward. With FRAC=8, 1*128 gives 1 and -1*128 gives 0.
- R5: If the shifted value exceeds 32767, `out_data` is 0x7FFF and `out_sat` is 1.
- R6: If the shifted value is below -32768, `out_data` is 0x8000 and `out_sat` is 1.
- R7: A shifted value inside [-32768, 32767] appears on `out_data` as its low 16 bits, with `out_sat` 0.
- R8: In a cycle that follows no accepted input, `out_data` and `out_sat` keep their previous values.
- R9: With FRAC=15, the product -32768 * -32768 is clamped to 0x7FFF with `out_sat` set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take an operand pair |
| in_a | input | 16 | First operand, signed, FRAC fraction bits |
| in_b | input | 16 | Second operand, signed, FRAC fraction bits |
| out_valid | output | 1 | Fresh result present |
| out_data | output | 16 | Rounded, clamped product |
| out_sat | output | 1 | Result was clamped |

## Verification
The bench runs two instances side by side, one with FRAC=8 and one with FRAC=15. Both see the same operands.

Positive and negative exact midpoints show whether rounding goes upward or merely toward zero or away from it. Products just past each bound show whether the block clamps or wraps, and also test the direction of the flag. The -32768 squared case at FRAC=15 finds a result that is off by one bit past the maximum.

Random operand pairs are mixed with idle cycles. These cover sign handling over the whole range and check that the output register holds its value while no input arrives.

// File: rtl/fxp_pkg.sv
package fxp_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } res_state_t;

endpackage

// File: rtl/fxp_round_shift.sv
module fxp_round_shift #(
    parameter int W    = 16,
    parameter int FRAC = 8,
    localparam int PW  = 2 * W + 1
) (
    input  logic [W-1:0]         op_a,
    input  logic [W-1:0]         op_b,
    output logic signed [PW-1:0] scaled
);
    localparam logic [PW-1:0] BIAS = {{(PW-1){1'b0}}, 1'b1} << (FRAC - 1);

    logic signed [PW-1:0] ext_a;
    logic signed [PW-1:0] ext_b;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] biased;

    always_comb begin
        ext_a  = {{(PW-W){op_a[W-1]}}, op_a};
        ext_b  = {{(PW-W){op_b[W-1]}}, op_b};
        prod   = ext_a * ext_b;
        biased = prod + $signed(BIAS);
        scaled = biased >>> FRAC;
    end

endmodule

// File: rtl/fxp_clamp.sv
module fxp_clamp #(
    parameter int W   = 16,
    localparam int PW = 2 * W + 1
) (
    input  logic signed [PW-1:0] wide,
    output logic [W-1:0]         narrow,
    output logic                 clipped
);
    localparam logic [W-1:0] MAXW = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINW = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [PW-1:0] HI = {{(PW-W){1'b0}}, MAXW};
    localparam logic signed [PW-1:0] LO = {{(PW-W){1'b1}}, MINW};

    always_comb begin
        if (wide > HI) begin
            narrow  = MAXW;
            clipped = 1'b1;
        end else if (wide < LO) begin
            narrow  = MINW;
            clipped = 1'b1;
        end else begin
            narrow  = wide[W-1:0];
            clipped = 1'b0;
        end
    end

    always_comb begin
        if (clipped) begin
            a_r5_r6_clip_extreme : assert (narrow == MAXW || narrow == MINW);
        end
    end

endmodule

// File: rtl/fxp_mul_rs.sv
module fxp_mul_rs #(
    parameter int FRAC = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] in_a,
    input  logic [15:0] in_b,
    output logic        out_valid,
    output logic [15:0] out_data,
    output logic        out_sat
);
    import fxp_pkg::*;

    localparam int W  = 16;
    localparam int PW = 2 * W + 1;

    generate
        if (FRAC < 1 || FRAC > W - 1) begin : g_bad_frac
            $error("FRAC must lie in 1..15");
        end
    endgenerate

    res_state_t           state, state_nx;
    logic                 take;
    logic signed [PW-1:0] scaled;
    logic [W-1:0]         clamped;
    logic                 clipped;

    assign in_ready = 1'b1;
    assign take     = in_valid && in_ready;

    fxp_round_shift #(.W(W), .FRAC(FRAC)) u_rs (
        .op_a   (in_a),
        .op_b   (in_b),
        .scaled (scaled)
    );

    fxp_clamp #(.W(W)) u_clamp (
        .wide    (scaled),
        .narrow  (clamped),
        .clipped (clipped)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: state_nx = take ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_nx = take ? ST_FULL : ST_EMPTY;
            default:  state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_EMPTY;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data <= '0;
            out_sat  <= 1'b0;
        end else if (take) begin
            out_data <= clamped;
            out_sat  <= clipped;
        end
    end

    assign out_valid = (state == ST_FULL);

    a_r1_reset_clears : assert property (@(posedge clk)
        rst |=> (!out_valid && !out_sat && out_data == '0));

    a_r3_valid_follows : assert property (@(posedge clk) disable iff (rst)
        take |=> out_valid);

    a_r3_no_spurious : assert property (@(posedge clk) disable iff (rst)
        !take |=> !out_valid);

    a_r8_hold : assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_data) && $stable(out_sat)));

    a_r2_ready : assert property (@(posedge clk) disable iff (rst)
        in_ready);

    a_r5_sat_value : assert property (@(posedge clk) disable iff (rst)
        out_sat |-> (out_data == 16'h7FFF || out_data == 16'h8000));

endmodule

// File: tb/fxp_mul_rs_tb.sv
module fxp_mul_rs_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] in_a, in_b;
    logic        rdy8, rdy15;
    logic        v8, v15, s8, s15;
    logic [15:0] d8, d15;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] e_d8 = '0, e_d15 = '0;
    logic        e_s8 = 1'b0, e_s15 = 1'b0, e_v = 1'b0;

    always #2 clk = ~clk;

    fxp_mul_rs #(.FRAC(8)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy8),
        .in_a(in_a), .in_b(in_b), .out_valid(v8), .out_data(d8), .out_sat(s8)
    );

    fxp_mul_rs #(.FRAC(15)) u_dut15 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy15),
        .in_a(in_a), .in_b(in_b), .out_valid(v15), .out_data(d15), .out_sat(s15)
    );

    function automatic logic [16:0] ref_mul(int q, logic [15:0] a, logic [15:0] b);
        longint p, r;
        p = longint'($signed(a)) * longint'($signed(b)) + (longint'(1) << (q - 1));
        r = p >>> q;
        if (r > 32767)       return {1'b1, 16'h7FFF};
        else if (r < -32768) return {1'b1, 16'h8000};
        else                 return {1'b0, r[15:0]};
    endfunction

    task automatic chk(logic ok, string tag, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(v8 == e_v,    {tag, " R3 valid q8"},  v8,  e_v);
        chk(v15 == e_v,   {tag, " R3 valid q15"}, v15, e_v);
        chk(d8 == e_d8,   {tag, " data q8"},      d8,  e_d8);
        chk(s8 == e_s8,   {tag, " sat q8"},       s8,  e_s8);
        chk(d15 == e_d15, {tag, " data q15"},     d15, e_d15);
        chk(s15 == e_s15, {tag, " sat q15"},      s15, e_s15);
    endtask

    task automatic step(logic v, logic [15:0] a, logic [15:0] b, string tag);
        logic [16:0] r8, r15;
        @(negedge clk);
        in_valid = v; in_a = a; in_b = b;
        chk(rdy8 && rdy15, {tag, " R2 ready"}, {rdy8, rdy15}, 2'b11);
        r8  = ref_mul(8, a, b);
        r15 = ref_mul(15, a, b);
        @(posedge clk);
        #1;
        e_v = v;
        if (v) begin
            {e_s8, e_d8}   = r8;
            {e_s15, e_d15} = r15;
        end
        compare(tag);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b1; in_a = 16'h7FFF; in_b = 16'h7FFF;
        repeat (3) @(posedge clk);
        #1;
        compare("R1 reset");
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;

        step(1, 16'h0180, 16'h0200, "R7 in-range 1.5x2");
        step(1, 16'h0001, 16'h0080, "R4 pos midpoint");
        chk(d8 == 16'h0001, "R4 q8 up", d8, 16'h0001);
        step(1, 16'hFFFF, 16'h0080, "R4 neg midpoint");
        chk(d8 == 16'h0000, "R4 q8 toward +inf", d8, 16'h0000);
        step(1, 16'h7FFF, 16'h7FFF, "R5 high clamp");
        chk(d8 == 16'h7FFF && s8, "R5 q8", {s8, d8}, 17'h17FFF);
        step(0, 16'h0001, 16'h0001, "R8 hold after clamp");
        step(1, 16'h7FFF, 16'h8000, "R6 low clamp");
        chk(d8 == 16'h8000 && s8, "R6 q8", {s8, d8}, 17'h18000);
        step(1, 16'h8000, 16'h8000, "R9 corner");
        chk(d15 == 16'h7FFF && s15, "R9 q15", {s15, d15}, 17'h17FFF);
        step(1, 16'hFF00, 16'h0300, "R7 negative in-range");
        step(0, 16'h1234, 16'h5678, "R8 idle");
        step(0, 16'h0000, 16'h0000, "R8 idle 2");
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 4) != 0, 16'($urandom), 16'($urandom), "R4 R7 random");
        end
        for (int i = 0; i < 100; i++) begin
            step(1, 16'($urandom % 512) - 16'd256, 16'($urandom % 512) - 16'd256, "R4 small");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule